// File: doc/BRIEF.md
# Single-level page table walker

This block turns a 32-bit virtual address into a physical address by reading one page table entry from memory. Pages are 4 KB, so the low 12 bits of the virtual address pass through untouched as the page offset and the upper 20 bits form the virtual page number. The walker reads the 4-byte entry at the table base plus four times the page number. It checks the entry's status bits and reports either the physical address or a fault.

Software loads the table base through a plain write port whenever a different address space is made active. Requests arrive on a valid/ready port with a write flag. The single memory read leaves on a valid/ready request channel and comes back as a one-cycle response strobe. The result is offered on a valid/ready response port.

Back-pressure rules:
- Once `req_valid` is accepted, `req_ready` stays low until the response has been taken.
- `mem_req_valid` and its address hold until `mem_req_ready` is seen.
- `rsp_valid` and its payload hold until `rsp_ready` is seen.

Top module: `pt_walk_top`

## Requirements
- R1: After reset `req_ready` is 1 while `mem_req_valid` and `rsp_valid` are 0.
- R2: For an accepted request, `mem_req_addr` equals the table base plus the virtual page number (`vaddr[31:12]`) times 4, modulo 2^32. The address stays stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R3: When no fault occurs, `rsp_paddr` equals entry bits 31:12 (frame number) joined above `vaddr[11:0]`. No addition is involved.
- R4: An entry with bit 0 (valid) clear, or with bit 1 (present) clear, gives `rsp_fault`=1 and `rsp_paddr`=0.
- R5: A write request (`req_write`=1) to an entry whose bit 2 (write permission) is clear faults with `rsp_paddr`=0. A read of that entry does not fault.
- R6: From acceptance until the response handshake, `req_ready` is 0. Exactly one memory read is issued per request, and `mem_req_valid` drops in the cycle after its handshake.
- R7: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady while `rsp_ready` is low.
- R8: A base write takes effect for requests accepted in later cycles. A request accepted in the same cycle as a base write uses the previous base.
- R9: Entry bit 3 (referenced) and bit 4 (dirty) have no effect on the result.
- R10: A `mem_rsp_valid` pulse while the memory read has not yet been handed off is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the page table base |
| base_wr_data | input | 32 | New page table base byte address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = access is a write |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry contents |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation faulted |

## Verification
The entry address is due on the memory port in the first cycle after the request handshake. `mem_req_valid` falls one cycle after the memory handshake. `rsp_valid`, `rsp_paddr` and `rsp_fault` appear one cycle after the read data strobe. `req_ready` returns one cycle after the response handshake. The bench drives every input on the falling clock edge and samples the outputs at the next falling edge after the registering edge. It holds each handshake partner stalled for a random number of cycles and re-checks the held values in every stalled cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // Entry status bit positions; the frame number sits above the page offset.
  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_PRES_BIT  = 1;
  localparam int unsigned PTE_WPERM_BIT = 2;
  localparam int unsigned PTE_REF_BIT   = 3;
  localparam int unsigned PTE_DIRTY_BIT = 4;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_WAIT  = 2'd2,
    WS_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_SHIFT = 2,
  parameter int unsigned AW        = 32
) (
  input  logic [AW-1:0]   base,
  input  logic [VA_W-1:0] vaddr,
  output logic [AW-1:0]   entry_addr
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;

  logic [VPN_W-1:0] vpn;
  logic [PAGE_BITS-1:0] unused_off;

  assign vpn        = vaddr[VA_W-1:PAGE_BITS];
  assign unused_off = vaddr[PAGE_BITS-1:0];
  assign entry_addr = base + (AW'(vpn) << PTE_SHIFT);
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned PA_W      = FRAME_W + PAGE_BITS
) (
  input  logic [DATA_W-1:0]    pte,
  input  logic [PAGE_BITS-1:0] offset,
  input  logic                 is_write,
  output logic [PA_W-1:0]      paddr,
  output logic                 fault
);
  logic [FRAME_W-1:0] frame;
  logic               unused_hist;
  logic               perm_bad;
  logic               map_bad;

  assign frame       = pte[PAGE_BITS +: FRAME_W];
  // Referenced and dirty bits are history only; they never change a result.
  assign unused_hist = pte[PTE_REF_BIT] ^ pte[PTE_DIRTY_BIT];
  assign map_bad     = !pte[PTE_VALID_BIT] || !pte[PTE_PRES_BIT];
  assign perm_bad    = is_write && !pte[PTE_WPERM_BIT];
  assign fault       = map_bad || perm_bad;

  generate
    if (PA_W > FRAME_W + PAGE_BITS) begin : g_wide
      assign paddr = fault ? '0 : {{(PA_W-FRAME_W-PAGE_BITS){1'b0}}, frame, offset};
    end else begin : g_exact
      assign paddr = fault ? '0 : {frame, offset};
    end
  endgenerate

  generate
    if (DATA_W > FRAME_W + PAGE_BITS) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^pte[DATA_W-1:FRAME_W+PAGE_BITS];
    end
  endgenerate

  logic unused_mid;
  assign unused_mid = ^pte[PAGE_BITS-1:PTE_DIRTY_BIT+1];
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic mem_req_valid,
  output logic rsp_valid,
  output logic accept,
  output logic mem_capture,
  output logic rsp_done
);
  walk_state_e state_q, state_d;

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_FETCH);
  assign rsp_valid     = (state_q == WS_RESP);
  assign accept        = req_ready && req_valid;
  assign mem_capture   = (state_q == WS_WAIT) && mem_rsp_valid;
  assign rsp_done      = rsp_valid && rsp_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE:  if (req_valid)     state_d = WS_FETCH;
      WS_FETCH: if (mem_req_ready) state_d = WS_WAIT;
      WS_WAIT:  if (mem_rsp_valid) state_d = WS_RESP;
      WS_RESP:  if (rsp_ready)     state_d = WS_IDLE;
      default:                     state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  // R6: one memory read per walk, and the channel drops right after its handshake.
  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R6: no new request is taken while a walk is in flight.
  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready until_with rsp_done);
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_BYTES = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned PA_W      = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [AW-1:0]     base_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault
);
  localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES);

  logic [AW-1:0]        base_q;
  logic [AW-1:0]        ent_addr_d, ent_addr_q;
  logic [PAGE_BITS-1:0] off_q;
  logic                 wr_q;
  logic [PA_W-1:0]      pa_d, pa_q;
  logic                 flt_d, flt_q;
  logic                 accept, mem_capture, rsp_done;

  pw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ready     (rsp_ready),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .rsp_valid     (rsp_valid),
    .accept        (accept),
    .mem_capture   (mem_capture),
    .rsp_done      (rsp_done)
  );

  pw_entry_addr #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTE_SHIFT(PTE_SHIFT), .AW(AW)
  ) u_addr (
    .base       (base_q),
    .vaddr      (req_vaddr),
    .entry_addr (ent_addr_d)
  );

  pw_entry_check #(
    .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W), .PA_W(PA_W)
  ) u_check (
    .pte      (mem_rsp_data),
    .offset   (off_q),
    .is_write (wr_q),
    .paddr    (pa_d),
    .fault    (flt_d)
  );

  // Base register: the old value serves any request accepted in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)          base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_addr_q <= '0;
      off_q      <= '0;
      wr_q       <= 1'b0;
    end else if (accept) begin
      ent_addr_q <= ent_addr_d;
      off_q      <= req_vaddr[PAGE_BITS-1:0];
      wr_q       <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q  <= '0;
      flt_q <= 1'b0;
    end else if (mem_capture) begin
      pa_q  <= pa_d;
      flt_q <= flt_d;
    end
  end

  assign mem_req_addr = ent_addr_q;
  assign rsp_paddr    = pa_q;
  assign rsp_fault    = flt_q;

  assert_mreq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == off_q));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));
endmodule

// File: tb/pt_walk_top_tb.sv
module pt_walk_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] base_model;
  logic [31:0] tbl [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walk_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl_idx_addr(input logic [31:0] a);
    return {28'd0, a[5:2]};
  endfunction

  // Expected translation from the requirement text (R3, R4, R5, R9).
  function automatic logic [32:0] model(input logic [31:0] pte, input logic [31:0] va,
                                        input bit wr);
    bit f;
    f = (pte[0] == 1'b0) || (pte[1] == 1'b0) || (wr && pte[2] == 1'b0);
    return f ? {1'b1, 32'd0} : {1'b0, pte[31:12], va[11:0]};
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_model = b;
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input int mstall,
                       input int lat, input int rstall, input bit spurious,
                       input bit same_base_wr, input logic [31:0] new_base);
    logic [31:0] exp_addr, pte;
    logic [32:0] exp;
    exp_addr = base_model + {va[31:12], 2'b00};
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    if (same_base_wr) begin base_wr_en = 1'b1; base_wr_data = new_base; end
    @(negedge clk);
    req_valid = 1'b0; base_wr_en = 1'b0;
    if (same_base_wr) base_model = new_base;
    chk(req_ready == 1'b0, "R6 busy after accept", {31'd0, req_ready}, 32'd0);
    chk(mem_req_valid == 1'b1, "R6 read issued", {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == exp_addr, same_base_wr ? "R8 old base used" : "R2 entry address",
        mem_req_addr, exp_addr);
    for (int i = 0; i < mstall; i++) begin
      if (spurious && i == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_F007; end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(mem_req_valid && mem_req_addr == exp_addr, "R2 address held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R6 single read", {31'd0, mem_req_valid}, 32'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    pte = tbl[tbl_idx_addr(exp_addr)];
    exp = model(pte, va, wr);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7 response valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_paddr == exp[31:0], spurious ? "R10 stray strobe ignored" : "R3 paddr",
        rsp_paddr, exp[31:0]);
    chk(rsp_fault == exp[32], "R4/R5 fault flag", {31'd0, rsp_fault}, {31'd0, exp[32]});
    for (int i = 0; i < rstall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == exp[31:0] && rsp_fault == exp[32] && !req_ready,
          "R7 result held", rsp_paddr, exp[31:0]);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R6 free after response",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    logic [31:0] pa_a, pa_b;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; base_wr_en = 1'b0; base_wr_data = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; rsp_ready = 1'b0;
    base_model = '0;
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // Directed: base 0x5000, entry 0 -> frame 2, entry 1 -> frame 0 (R3, R8)
    set_base(32'h0000_5000);
    tbl[0] = 32'h0000_2007; tbl[1] = 32'h0000_0007;
    xlate(32'h0000_0010, 1'b0, 0, 0, 0, 1'b0, 1'b0, '0);
    xlate(32'h0000_1100, 1'b1, 2, 1, 2, 1'b0, 1'b0, '0);
    // R4: invalid and not-present entries
    tbl[2] = 32'h0001_2006;
    xlate(32'h0000_2ABC, 1'b0, 1, 0, 0, 1'b0, 1'b0, '0);
    tbl[3] = 32'h0001_3005;
    xlate(32'h0000_3ABC, 1'b0, 0, 2, 1, 1'b0, 1'b0, '0);
    // R5: read-only page, read passes then write faults
    tbl[4] = 32'h0ABC_D003;
    xlate(32'h0000_4123, 1'b0, 0, 0, 0, 1'b0, 1'b0, '0);
    xlate(32'h0000_4123, 1'b1, 0, 0, 0, 1'b0, 1'b0, '0);
    // R9: referenced/dirty bits do not matter
    tbl[5] = 32'h0055_5007;
    xlate(32'h0000_5FFF, 1'b1, 0, 0, 0, 1'b0, 1'b0, '0);
    pa_a = rsp_paddr;
    tbl[5] = 32'h0055_501F;
    xlate(32'h0000_5FFF, 1'b1, 0, 0, 0, 1'b0, 1'b0, '0);
    pa_b = rsp_paddr;
    chk(pa_a == pa_b, "R9 history bits ignored", pa_b, pa_a);
    // R10: stray data strobe while read not yet handed off
    xlate(32'h0000_1234, 1'b0, 3, 0, 0, 1'b1, 1'b0, '0);
    // R8: same-cycle base write uses old base; next request uses the new one
    tbl[0] = 32'h0077_7007;
    xlate(32'h0000_0020, 1'b0, 0, 0, 0, 1'b0, 1'b1, 32'h0010_0000);
    xlate(32'h0000_0020, 1'b0, 0, 0, 0, 1'b0, 1'b0, '0);
    chk(mem_req_addr == 32'h0010_0000, "R8 new base in effect", mem_req_addr, 32'h0010_0000);

    // Constrained random walks
    for (int n = 0; n < 60; n++) begin
      if (n % 15 == 0) set_base($urandom & 32'hFFFF_FFFC);
      for (int i = 0; i < 16; i++) tbl[i] = $urandom;
      xlate($urandom, 1'($urandom), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4), ($urandom % 5) == 0, ($urandom % 7) == 0,
            $urandom & 32'hFFFF_FFFC);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule